// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock

This peripheral keeps wall-clock time and a calendar date in packed binary-coded-decimal registers that software reads directly over a simple synchronous register bus. A clock-enable input, pulsed at the oscillator rate, drives a two-stage divider: a short first stage and a wide second stage. Their combined ratio yields one calendar tick per second. Each tick advances seconds, minutes and hours in 24-hour form. Days roll over by month length, including leap-year Februaries. The weekday cycles 1 to 7, and the two-digit year wraps from 99 to 00.

Software changes the clock in a fixed order. It writes a two-value key to unlock the registers. It then requests initialization mode, which freezes the calendar. It waits for the acknowledge flag, writes time, date and divider, and releases initialization. A sticky programmed flag tells firmware after reset whether the calendar has ever been set.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: Word addresses are 0 time, 1 date, 2 control/status, 3 key, 4 divider. Read data is combinational from the address. After reset the registers read time 0x00000000, date 0x00002101 (day 01, month 01, weekday 1, year 00), control 0x00000000 and divider 0x007F00FF.
- R2: Key unlock works as follows. A key write of 0xCA followed by a key write of 0x53 opens the registers. Any other key value, including 0x00, closes them, and so does a wrong value after 0xCA.
- R3: Writes to control are ignored while the registers are closed. Writes to time, date and divider are ignored unless the registers are open and the init acknowledge (control bit 1) is set.
- R4: Control bit 0 is the init request. Control bit 1, the acknowledge, reads 1 two clocks after the request is set and reads 0 in the same cycle that the request clears.
- R5: While the init request is set the calendar does not advance. While the acknowledge is set both divider counters are held at zero.
- R6: The divider register holds the first-stage ratio minus one in bits 22:16 and the second-stage ratio minus one in bits 14:0. A tick occurs every (first+1)×(second+1) enable pulses.
- R7: The time register holds BCD seconds in bits 6:0, minutes in bits 14:8 and hours in bits 21:16. Seconds and minutes wrap after 59 and hours after 23. Bit 22 (PM) always reads 0.
- R8: The date register holds BCD day in bits 5:0, month in bits 12:8, weekday in bits 15:13 and year in bits 23:16. The day wraps to 01 after the month's last day: 30 for months 04, 06, 09 and 11, 29 for February in a year divisible by 4, 28 for other Februaries, and 31 otherwise.
- R9: A month wrap from 12 goes to 01 and increments the year, and year 99 goes to 00.
- R10: The weekday increments on each day advance and wraps from 7 to 1.
- R11: Control bit 2 reads 0 after reset and becomes 1, permanently, once the date register has been written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Oscillator clock-enable pulse feeding the divider |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |

## Verification
A wrong key state shows up within one bus cycle. A control write then fails to set bit 0, and a guarded write leaves the time or date readback unchanged. A broken handshake or freeze shows on the acknowledge bit two clocks after the request. It also shows in the time register after a burst of enable pulses taken while frozen. Divider and calendar defects appear on the very tick that crosses a boundary: one tick early or late, or a wrong day, month, weekday or year in the readback straight after it.

// File: rtl/rtc_pkg.sv
// Package: shared register map, widths and BCD calendar helpers.
// Assumes all calendar fields are held as two-digit BCD bytes.
package rtc_pkg;
    localparam int DATA_W = 32;
    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] A_TIME  = 3'd0;
    localparam logic [REG_AW-1:0] A_DATE  = 3'd1;
    localparam logic [REG_AW-1:0] A_CTRL  = 3'd2;
    localparam logic [REG_AW-1:0] A_KEY   = 3'd3;
    localparam logic [REG_AW-1:0] A_DIV   = 3'd4;

    // One BCD step: returns {wrapped, next}; wraps to 'first' at or past 'last'.
    function automatic logic [8:0] bcd_step(logic [7:0] v, logic [7:0] last,
                                            logic [7:0] first);
        logic [3:0] t;
        logic [3:0] u;
        t = v[7:4];
        u = v[3:0];
        if (v >= last)       return {1'b1, first};
        else if (u >= 4'd9)  return {1'b0, t + 4'd1, 4'd0};
        else                 return {1'b0, t, u + 4'd1};
    endfunction

    // Last BCD day of a BCD month in a two-digit BCD year.
    function automatic logic [7:0] month_end(logic [7:0] mon, logic [7:0] yr);
        logic [7:0] ybin;
        ybin = ({4'd0, yr[7:4]} * 8'd10) + {4'd0, yr[3:0]};
        case (mon)
            8'h02:                      return (ybin[1:0] == 2'd0) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_keylock.sv
// Module: two-write key sequence that opens the guarded registers.
// Assumes one key write per bus cycle; any off-sequence value closes.
module rtc_keylock #(
    parameter int          KEY_W = 8,
    parameter logic [KEY_W-1:0] KEY_A = 8'hCA,
    parameter logic [KEY_W-1:0] KEY_B = 8'h53
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_val,
    output logic             is_open
);
    typedef enum logic [1:0] {K_SHUT, K_HALF, K_OPEN} kstate_t;
    kstate_t st;

    // Advance the key sequence on every key write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= K_SHUT;
        end else if (key_wr) begin
            if (st == K_HALF && key_val == KEY_B) st <= K_OPEN;
            else if (key_val == KEY_A)            st <= K_HALF;
            else                                  st <= K_SHUT;
        end
    end

    assign is_open = (st == K_OPEN);
endmodule

// File: rtl/rtc_prescaler.sv
// Module: two-stage divider turning enable pulses into one tick per period.
// Assumes limits are ratio-minus-one; hold forces both counters to zero.
module rtc_prescaler #(
    parameter int AW = 7,
    parameter int SW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          hold,
    input  logic [AW-1:0] a_lim,
    input  logic [SW-1:0] s_lim,
    output logic          tick,
    output logic          at_zero
);
    logic [AW-1:0] a_cnt;
    logic [SW-1:0] s_cnt;
    logic          a_wrap;

    assign a_wrap  = en && (a_cnt >= a_lim);
    assign tick    = !hold && a_wrap && (s_cnt >= s_lim);
    assign at_zero = (a_cnt == '0) && (s_cnt == '0);

    // First stage counts enable pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || hold)  a_cnt <= '0;
        else if (a_wrap)     a_cnt <= '0;
        else if (en)         a_cnt <= a_cnt + 1'b1;
    end

    // Second stage counts first-stage wraps.
    always_ff @(posedge clk) begin
        if (!rst_n || hold)  s_cnt <= '0;
        else if (tick)       s_cnt <= '0;
        else if (a_wrap)     s_cnt <= s_cnt + 1'b1;
    end
endmodule

// File: rtl/rtc_calendar.sv
// Module: BCD time/date registers with 24-hour and month-length rollover.
// Assumes bus writes and advance never coincide (writes need init mode).
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              wr_time,
    input  logic              wr_date,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] time_word,
    output logic [DATA_W-1:0] date_word,
    output logic              programmed
);
    logic [7:0] sec, mins, hrs, day, mon, yr;
    logic [2:0] wday;
    logic [8:0] sec_n, min_n, hr_n, day_n, mon_n, yr_n;
    logic [2:0] wday_n;

    // Chain of BCD steps, each carrying into the next field.
    always_comb begin
        sec_n  = bcd_step(sec,  8'h59, 8'h00);
        min_n  = bcd_step(mins, 8'h59, 8'h00);
        hr_n   = bcd_step(hrs,  8'h23, 8'h00);
        day_n  = bcd_step(day,  month_end(mon, yr), 8'h01);
        mon_n  = bcd_step(mon,  8'h12, 8'h01);
        yr_n   = bcd_step(yr,   8'h99, 8'h00);
        wday_n = (wday >= 3'd7) ? 3'd1 : wday + 3'd1;
    end

    // Load from bus or advance by one second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec <= 8'h00; mins <= 8'h00; hrs <= 8'h00;
            day <= 8'h01; mon <= 8'h01; yr <= 8'h00; wday <= 3'd1;
            programmed <= 1'b0;
        end else if (wr_time || wr_date) begin
            if (wr_time) begin
                sec  <= {1'b0, wdata[6:0]};
                mins <= {1'b0, wdata[14:8]};
                hrs  <= {2'b0, wdata[21:16]};
            end
            if (wr_date) begin
                day  <= {2'b0, wdata[5:0]};
                mon  <= {3'b0, wdata[12:8]};
                wday <= wdata[15:13];
                yr   <= wdata[23:16];
                programmed <= 1'b1;
            end
        end else if (adv) begin
            sec <= sec_n[7:0];
            if (sec_n[8]) begin
                mins <= min_n[7:0];
                if (min_n[8]) begin
                    hrs <= hr_n[7:0];
                    if (hr_n[8]) begin
                        day  <= day_n[7:0];
                        wday <= wday_n;
                        if (day_n[8]) begin
                            mon <= mon_n[7:0];
                            if (mon_n[8]) yr <= yr_n[7:0];
                        end
                    end
                end
            end
        end
    end

    // Pack fields into the readable words (PM bit fixed at 0).
    always_comb begin
        time_word = '0;
        time_word[6:0]   = sec[6:0];
        time_word[14:8]  = mins[6:0];
        time_word[21:16] = hrs[5:0];
        date_word = '0;
        date_word[5:0]   = day[5:0];
        date_word[12:8]  = mon[4:0];
        date_word[15:13] = wday;
        date_word[23:16] = yr;
    end
endmodule

// File: rtl/rtc_bcd_calendar.sv
// Module: top of the real-time clock; bus decode, init handshake, divider
// register and read mux. Assumes a single-cycle synchronous register bus.
module rtc_bcd_calendar
    import rtc_pkg::*;
#(
    parameter int AW        = 7,
    parameter int SW        = 15,
    parameter int A_RST     = 127,
    parameter int S_RST     = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int A_LSB = 16;

    logic              key_open;
    logic              init_req, init_s1, init_s2, init_ack;
    logic              guarded_ok;
    logic [AW-1:0]     a_lim;
    logic [SW-1:0]     s_lim;
    logic              sec_tick, adv, pre_zero, programmed;
    logic [DATA_W-1:0] time_reg, date_reg;

    rtc_keylock u_key (
        .clk(clk), .rst_n(rst_n),
        .key_wr(bus_we && bus_addr == A_KEY),
        .key_val(bus_wdata[7:0]),
        .is_open(key_open)
    );

    // Init request, writable only with the key open.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      init_req <= 1'b0;
        else if (bus_we && bus_addr == A_CTRL && key_open) init_req <= bus_wdata[0];
    end

    // Two-stage acknowledge delay following the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_s1 <= 1'b0;
            init_s2 <= 1'b0;
        end else begin
            init_s1 <= init_req;
            init_s2 <= init_req && init_s1;
        end
    end
    assign init_ack   = init_s2 && init_req;
    assign guarded_ok = key_open && init_ack;

    // Divider limits, loadable only in init mode with the key open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_lim <= AW'(A_RST);
            s_lim <= SW'(S_RST);
        end else if (bus_we && bus_addr == A_DIV && guarded_ok) begin
            a_lim <= bus_wdata[A_LSB +: AW];
            s_lim <= bus_wdata[0 +: SW];
        end
    end

    rtc_prescaler #(.AW(AW), .SW(SW)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(tick_en), .hold(init_ack),
        .a_lim(a_lim), .s_lim(s_lim), .tick(sec_tick), .at_zero(pre_zero)
    );

    assign adv = sec_tick && !init_req;

    rtc_calendar u_cal (
        .clk(clk), .rst_n(rst_n), .adv(adv),
        .wr_time(bus_we && bus_addr == A_TIME && guarded_ok),
        .wr_date(bus_we && bus_addr == A_DATE && guarded_ok),
        .wdata(bus_wdata),
        .time_word(time_reg), .date_word(date_reg), .programmed(programmed)
    );

    // Read mux by word address.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_TIME: bus_rdata = time_reg;
            A_DATE: bus_rdata = date_reg;
            A_CTRL: bus_rdata[2:0] = {programmed, init_ack, init_req};
            A_DIV: begin
                bus_rdata[A_LSB +: AW] = a_lim;
                bus_rdata[0 +: SW]     = s_lim;
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtc_bcd_calendar_chk.sv
// Module: property checker for rtc_bcd_calendar, attached by bind.
// Assumes it observes the top's own nets; drives nothing.
module rtc_bcd_calendar_chk
    import rtc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              init_req,
    input logic              init_ack,
    input logic              pre_zero,
    input logic              key_open,
    input logic              programmed,
    input logic              bus_we,
    input logic [REG_AW-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] time_reg
);
    // R4
    initf_needs_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_ack |-> init_req);
    // R4
    initf_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_ack) |-> ($past(init_req) && $past(init_req, 2)));
    // R5
    divider_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_ack |=> pre_zero);
    // R5
    frozen_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (init_req && !(bus_we && bus_addr == A_TIME)) |=> $stable(time_reg));
    // R2
    unlock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_open) |-> $past(bus_we && bus_addr == A_KEY && bus_wdata[7:0] == 8'h53));
    // R11
    inits_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        programmed |=> programmed);
endmodule

bind rtc_bcd_calendar rtc_bcd_calendar_chk u_chk (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_ack(init_ack),
    .pre_zero(pre_zero), .key_open(key_open), .programmed(programmed),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .time_reg(time_reg)
);

// File: tb/sim_rtc_bcd_calendar.sv
module sim_rtc_bcd_calendar;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    localparam logic [2:0] TM = 3'd0, DT = 3'd1, CT = 3'd2, KY = 3'd3, DV = 3'd4;

    always #2 clk = ~clk;

    rtc_bcd_calendar u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%08h exp=%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic unlock();
        wr(KY, 32'hCA);
        wr(KY, 32'h53);
    endtask

    task automatic program_cal(input logic [31:0] dv, input logic [31:0] t, input logic [31:0] d);
        unlock();
        wr(CT, 32'h1);
        repeat (2) @(negedge clk);
        wr(DV, dv);
        wr(TM, t);
        wr(DT, d);
        wr(CT, 32'h0);
    endtask

    task automatic pulses(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset_values();
        logic [31:0] v;
        do_reset();
        rd(TM, v); check("R1 time reset", v, 32'h0);
        rd(DT, v); check("R1 date reset", v, 32'h00002101);
        rd(CT, v); check("R11 ctrl reset", v, 32'h0);
        rd(DV, v); check("R1 divider reset", v, 32'h007F00FF);
    endtask

    task automatic t_locked_ignore();
        logic [31:0] v;
        do_reset();
        wr(TM, 32'h00123456);
        rd(TM, v); check("R3 locked time write", v, 32'h0);
        wr(CT, 32'h1);
        rd(CT, v); check("R3 locked ctrl write", v, 32'h0);
        unlock();
        wr(DT, 32'h00994231);
        rd(DT, v); check("R3 open but no init date write", v, 32'h00002101);
        wr(DV, 32'h0);
        rd(DV, v); check("R3 open but no init divider write", v, 32'h007F00FF);
    endtask

    task automatic t_wrong_key();
        logic [31:0] v;
        do_reset();
        wr(KY, 32'hCA); wr(KY, 32'h11);
        wr(CT, 32'h1);
        rd(CT, v); check("R2 wrong second key", v, 32'h0);
        unlock();
        wr(KY, 32'h00);
        wr(CT, 32'h1);
        rd(CT, v); check("R2 zero relocks", v, 32'h0);
        unlock();
        wr(CT, 32'h1);
        rd(CT, v); check("R2 correct sequence opens", v, 32'h1);
        wr(CT, 32'h0);
    endtask

    task automatic t_init_freeze();
        logic [31:0] v;
        do_reset();
        program_cal(32'h0, 32'h00000010, 32'h00012101);
        rd(CT, v); check("R11 programmed after date write", v, 32'h4);
        wr(CT, 32'h1);
        rd(CT, v); check("R4 ack low after 0 clocks", v, 32'h5);
        @(negedge clk);
        rd(CT, v); check("R4 ack low after 1 clock", v, 32'h5);
        @(negedge clk);
        rd(CT, v); check("R4 ack high after 2 clocks", v, 32'h7);
        pulses(10);
        rd(TM, v); check("R5 frozen while init", v, 32'h00000010);
        wr(CT, 32'h0);
        rd(CT, v); check("R4 ack drops with request", v, 32'h4);
        pulses(1);
        rd(TM, v); check("R5 resumes after init", v, 32'h00000011);
    endtask

    task automatic roll(input string req, input logic [31:0] t0, input logic [31:0] d0,
                        input logic [31:0] t1, input logic [31:0] d1);
        logic [31:0] v;
        program_cal(32'h00000001, t0, d0);
        pulses(2);
        rd(TM, v); check({req, " time"}, v, t1);
        rd(DT, v); check({req, " date"}, v, d1);
    endtask

    task automatic t_rollover();
        do_reset();
        roll("R7 minute carry",      32'h00125959, 32'h00052430, 32'h00130000, 32'h00052430);
        roll("R8 Feb 28 leap",       32'h00235959, 32'h0024E228, 32'h00000000, 32'h00242229);
        roll("R8 Feb 29 to Mar",     32'h00235959, 32'h00246229, 32'h00000000, 32'h00248301);
        roll("R8 Feb 28 non-leap",   32'h00235959, 32'h00234228, 32'h00000000, 32'h00236301);
        roll("R8 Apr 30",            32'h00235959, 32'h00052430, 32'h00000000, 32'h00054501);
        roll("R9 year 99 wrap",      32'h00235959, 32'h0099B231, 32'h00000000, 32'h0000C101);
        roll("R10 weekday 7 to 1",   32'h00235959, 32'h0010E115, 32'h00000000, 32'h00102116);
    endtask

    task automatic t_divider_rate();
        logic [31:0] v;
        do_reset();
        program_cal(32'h00010002, 32'h0, 32'h00012101);
        rd(DV, v); check("R6 divider readback", v, 32'h00010002);
        pulses(5);
        rd(TM, v); check("R6 no tick after 5 pulses", v, 32'h0);
        pulses(1);
        rd(TM, v); check("R6 tick on 6th pulse", v, 32'h00000001);
        pulses(6);
        rd(TM, v); check("R6 second tick after 6 more", v, 32'h00000002);
    endtask

    initial begin
        t_reset_values();
        t_locked_ignore();
        t_wrong_key();
        t_init_freeze();
        t_rollover();
        t_divider_rate();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule